// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Aligner

The aligner sits between an instruction memory port and a decoder. It asks memory for naturally aligned 64-bit fetch words. It buffers each word and hands the decoder one whole instruction at a time. An instruction is either a standard 32-bit instruction or an extended 64-bit instruction. The length is read from the two lowest bits of the first 32-bit slot: the pattern 11 marks a 32-bit instruction, and any other pattern marks a 64-bit instruction. A 64-bit instruction may only begin on an 8-byte boundary. Because of this, an instruction never spans two fetch words. Software places a 32-bit NOP in front of a 64-bit instruction that would otherwise start at an address of 4 mod 8.

The block tracks the fetch PC. It steps the PC by 4 or by 8 bytes. It selects the lower or upper slot of the buffered word from PC bit 2. After it issues a 32-bit instruction from the lower slot, it issues the upper slot of the same word without a second memory access. A 64-bit-format slot found at an upper-slot address is not issued. Instead the block raises a misalignment error and stops fetching until a redirect arrives.

A redirect input restarts fetch at a new PC, with the two low bits forced to zero. Any buffered word is dropped. A response that is still in flight is also dropped. The memory side allows one outstanding request at a time.

Top module: `fetch_aligner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_req_valid` is 1, `mem_req_addr` is `RESET_PC` with its three low bits cleared, `ins_valid` is 0 and `misalign_err` is 0.
- R2: Every memory request address has its three low bits equal to zero.
- R3: A slot whose bits [1:0] are 11 is issued as a 32-bit instruction. `ins_is64` is 0, `ins_data[31:0]` is the slot, `ins_data[63:32]` is zero, and the next PC is the current PC plus 4.
- R4: A slot whose bits [1:0] are not 11, at a PC that is 0 mod 8, is issued as a 64-bit instruction. `ins_is64` is 1, `ins_data` is the whole fetch word (upper slot in bits [63:32]), and the next PC is the current PC plus 8.
- R5: Each fetch word is requested from memory exactly once per pass. A 32-bit instruction in the lower slot is followed by the upper slot with no new request, and no request is made while an instruction is offered.
- R6: A slot whose bits [1:0] are not 11, at a PC that is 4 mod 8, is never issued. The block raises `misalign_err`, and `ins_pc` shows the offending PC.
- R7: Once `misalign_err` is raised, it stays high and no memory request is made until a redirect.
- R8: While `ins_valid` is 1 and `ins_ready` is 0 (with no redirect), the offered instruction, its PC and its valid stay unchanged in the next cycle.
- R9: A redirect sets the PC to `redir_pc` with bits [1:0] cleared. It discards the buffered word and any in-flight memory response, so the next instruction issued comes from the new PC.
- R10: A redirect to a PC that is 4 mod 8 issues the upper slot of that word first, and the lower slot is not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Restart fetch at `redir_pc` |
| redir_pc | input | PC_W | New fetch PC (bits [1:0] ignored) |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_addr | output | PC_W | 8-byte aligned fetch word address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Fetch word returned |
| mem_rsp_data | input | 64 | Returned fetch word, lower address in bits [31:0] |
| ins_valid | output | 1 | Instruction offered to the decoder |
| ins_ready | input | 1 | Decoder accepts the instruction |
| ins_data | output | 64 | Instruction bits, zero-extended for 32-bit |
| ins_pc | output | PC_W | PC of the offered (or faulting) instruction |
| ins_is64 | output | 1 | 1 for a 64-bit instruction |
| misalign_err | output | 1 | 64-bit-format slot seen at an address of 4 mod 8 |

## Verification
The checker assumes that the memory returns exactly one response per accepted request, and only while that request is outstanding. It also assumes that a redirect is a single-cycle pulse that is not asserted while reset is active. The bench memory model follows these rules. It holds a single pending request, it answers after a latency of one to three cycles, and it forces both ready inputs low in any cycle that carries a redirect. The sweep covers every pair of lower-slot and upper-slot length codes at both start offsets, with varying backpressure, so the misalignment, padding and upper-slot paths are all reached. In the flush case the stale response arrives while the block is draining.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int FA_SLOT_W = 32;
    localparam int FA_WORD_W = 64;

    typedef enum logic [2:0] {
        FA_REQ,    // present a request for the word holding pc
        FA_WAIT,   // request accepted, waiting for data
        FA_DRAIN,  // discard a response made stale by a redirect
        FA_HOLD,   // word buffered, offering instructions
        FA_HALT    // misaligned wide instruction found
    } fa_state_e;
endpackage

// File: rtl/fa_slot_sel.sv
module fa_slot_sel
    import fa_pkg::*;
(
    input  logic [FA_WORD_W-1:0] word,
    input  logic                 upper_sel,
    output logic                 is_std,
    output logic [FA_WORD_W-1:0] payload
);
    localparam int NSLOT = FA_WORD_W / FA_SLOT_W;

    logic [FA_SLOT_W-1:0] slots [NSLOT];
    logic [FA_SLOT_W-1:0] slot;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slots[g] = word[g*FA_SLOT_W +: FA_SLOT_W];
    end

    assign slot    = slots[upper_sel];
    assign is_std  = (slot[1:0] == 2'b11);
    assign payload = is_std ? {{(FA_WORD_W-FA_SLOT_W){1'b0}}, slot} : word;
endmodule

// File: rtl/fa_pc_step.sv
module fa_pc_step #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] pc,
    input  logic            is_std,
    output logic [PC_W-1:0] pc_next,
    output logic            leaves_word
);
    localparam logic [PC_W-1:0] STEP_STD  = PC_W'(4);
    localparam logic [PC_W-1:0] STEP_WIDE = PC_W'(8);

    assign pc_next     = pc + (is_std ? STEP_STD : STEP_WIDE);
    assign leaves_word = is_std ? pc[2] : 1'b1;
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 redir_valid,
    input  logic [PC_W-1:0]      redir_pc,
    output logic                 mem_req_valid,
    output logic [PC_W-1:0]      mem_req_addr,
    input  logic                 mem_req_ready,
    input  logic                 mem_rsp_valid,
    input  logic [FA_WORD_W-1:0] mem_rsp_data,
    output logic                 ins_valid,
    input  logic                 ins_ready,
    output logic [FA_WORD_W-1:0] ins_data,
    output logic [PC_W-1:0]      ins_pc,
    output logic                 ins_is64,
    output logic                 misalign_err
);
    typedef struct packed {
        fa_state_e            st;
        logic [PC_W-1:0]      pc;
        logic [FA_WORD_W-1:0] word;
    } fa_regs_t;

    fa_regs_t r_q, r_d;

    logic                 slot_std;
    logic [FA_WORD_W-1:0] slot_payload;
    logic [PC_W-1:0]      pc_step;
    logic                 leaves_word;
    logic                 wide_misaligned;
    logic                 in_flight;

    fa_slot_sel u_slot (
        .word      (r_q.word),
        .upper_sel (r_q.pc[2]),
        .is_std    (slot_std),
        .payload   (slot_payload)
    );

    fa_pc_step #(.PC_W(PC_W)) u_step (
        .pc          (r_q.pc),
        .is_std      (slot_std),
        .pc_next     (pc_step),
        .leaves_word (leaves_word)
    );

    assign wide_misaligned = !slot_std && r_q.pc[2];

    assign mem_req_valid = (r_q.st == FA_REQ);
    assign mem_req_addr  = {r_q.pc[PC_W-1:3], 3'b000};
    assign ins_valid     = (r_q.st == FA_HOLD) && !wide_misaligned;
    assign ins_data      = slot_payload;
    assign ins_pc        = r_q.pc;
    assign ins_is64      = !slot_std;
    assign misalign_err  = (r_q.st == FA_HALT);

    // a request is (or is about to be) outstanding without its data
    assign in_flight = ((r_q.st == FA_REQ)   && mem_req_ready)
                    || ((r_q.st == FA_WAIT)  && !mem_rsp_valid)
                    || ((r_q.st == FA_DRAIN) && !mem_rsp_valid);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            FA_REQ: begin
                if (mem_req_ready) r_d.st = FA_WAIT;
            end
            FA_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.word = mem_rsp_data;
                    r_d.st   = FA_HOLD;
                end
            end
            FA_DRAIN: begin
                if (mem_rsp_valid) r_d.st = FA_REQ;
            end
            FA_HOLD: begin
                if (wide_misaligned) begin
                    r_d.st = FA_HALT;
                end else if (ins_ready) begin
                    r_d.pc = pc_step;
                    r_d.st = leaves_word ? FA_REQ : FA_HOLD;
                end
            end
            FA_HALT: begin
                r_d.st = FA_HALT;
            end
            default: r_d.st = FA_REQ;
        endcase

        if (redir_valid) begin
            r_d.pc = {redir_pc[PC_W-1:2], 2'b00};
            r_d.st = in_flight ? FA_DRAIN : FA_REQ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= FA_REQ;
            r_q.pc   <= {RESET_PC[PC_W-1:2], 2'b00};
            r_q.word <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/fetch_aligner_chk.sv
module fetch_aligner_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            redir_valid,
    input logic [PC_W-1:0] redir_pc,
    input logic            mem_req_valid,
    input logic [PC_W-1:0] mem_req_addr,
    input logic            ins_valid,
    input logic            ins_ready,
    input logic [63:0]     ins_data,
    input logic [PC_W-1:0] ins_pc,
    input logic            ins_is64,
    input logic            misalign_err
);
    AST_REQ_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R2

    AST_STD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_is64) |-> (ins_data[63:32] == 32'h0 && ins_data[1:0] == 2'b11)); // R3

    AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_is64) |-> (ins_pc[2:0] == 3'b000 && ins_data[1:0] != 2'b11)); // R4

    AST_NO_REQ_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> !mem_req_valid); // R5

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> (!ins_valid && !mem_req_valid)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign_err && !redir_valid) |=> misalign_err); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready && !redir_valid)
        |=> (ins_valid && $stable(ins_data) && $stable(ins_pc))); // R8

    AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (ins_pc[PC_W-1:2] == $past(redir_pc[PC_W-1:2])
                         && ins_pc[1:0] == 2'b00 && !misalign_err)); // R9
endmodule

bind fetch_aligner fetch_aligner_chk #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .redir_valid   (redir_valid),
    .redir_pc      (redir_pc),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .ins_data      (ins_data),
    .ins_pc        (ins_pc),
    .ins_is64      (ins_is64),
    .misalign_err  (misalign_err)
);

// File: tb/fetch_aligner_tb.sv
module fetch_aligner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_pc = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        ins_valid;
    logic        ins_ready = 1'b0;
    logic [63:0] ins_data;
    logic [31:0] ins_pc;
    logic        ins_is64;
    logic        misalign_err;

    always #10 clk = ~clk;

    fetch_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_data(ins_data), .ins_pc(ins_pc), .ins_is64(ins_is64),
        .misalign_err(misalign_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int req_cnt = 0;
    int pat = 0;
    int lat = 1;
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic [31:0] paddr = '0;
    logic [1:0]  kind_tab [16];
    logic        stall = 1'b0;
    logic [63:0] stall_data = '0;
    logic [31:0] stall_pc = '0;

    function automatic logic [31:0] slot_val(input logic [31:0] a);
        return {a[31:2] ^ 30'h2AAAAAAA, kind_tab[a[5:2]]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input bit do_redir, input logic [31:0] rpc);
        @(negedge clk);
        cyc++;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            pcnt--;
            if (pcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = {slot_val(paddr + 32'd4), slot_val(paddr)};
                pend = 1'b0;
            end
        end
        if (stall && rst_n)
            check(ins_valid && ins_data == stall_data && ins_pc == stall_pc,
                  "R8 held offer", {ins_pc, ins_data[31:0]}, {stall_pc, stall_data[31:0]});
        if (do_redir) begin
            mem_req_ready = 1'b0;
            ins_ready     = 1'b0;
        end else begin
            mem_req_ready = ((cyc + pat) % 4) != 1;
            ins_ready     = ((cyc + pat) % 3) != 0;
        end
        redir_valid = do_redir;
        redir_pc    = rpc;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            req_cnt++;
            check(mem_req_addr[2:0] == 3'b000, "R2 request alignment",
                  64'(mem_req_addr), 64'(mem_req_addr & ~32'd7));
            pend  = 1'b1;
            pcnt  = lat;
            paddr = mem_req_addr;
        end
        stall      = ins_valid && !ins_ready && !redir_valid;
        stall_data = ins_data;
        stall_pc   = ins_pc;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) tick(1'b0, '0);
        @(negedge clk);
        cyc++;
        mem_req_ready = 1'b0;
        ins_ready     = 1'b0;
        mem_rsp_valid = 1'b0;
        pend  = 1'b0;
        stall = 1'b0;
        rst_n = 1'b1;
        // R1: state right after reset release
        check(mem_req_valid && mem_req_addr == 32'h0 && !ins_valid && !misalign_err,
              "R1 reset state", {31'b0, mem_req_valid, mem_req_addr},
              {31'b0, 1'b1, 32'h0});
    endtask

    task automatic run(input logic [31:0] start, input int nitems, input bit chk_req);
        logic [31:0] mpc;
        logic [28:0] lw;
        logic [1:0]  k;
        logic [63:0] exp_d;
        logic        is64;
        int items, wcnt, guard, rc;
        bit done;
        string tag;
        mpc = start & ~32'd3;
        lw = '1;
        items = 0; wcnt = 0; guard = 0; done = 0;
        while (!done && guard < 400) begin
            guard++;
            k = kind_tab[mpc[5:2]];
            if (k != 2'b11 && mpc[2]) begin
                if (misalign_err) begin
                    if (mpc[31:3] != lw) wcnt++;
                    check(!ins_valid && ins_pc == mpc, "R6 misaligned wide slot",
                          {31'b0, ins_valid, ins_pc}, {32'b0, mpc});
                    rc = req_cnt;
                    repeat (4) tick(1'b0, '0);
                    check(misalign_err && req_cnt == rc, "R7 halted",
                          64'(req_cnt), 64'(rc));
                    if (chk_req)
                        check(rc == wcnt, "R5 request count", 64'(rc), 64'(wcnt));
                    done = 1;
                end else if (ins_valid && ins_ready) begin
                    check(1'b0, "R6 issued misaligned", 64'(ins_pc), 64'(mpc));
                    done = 1;
                end
            end else if (ins_valid && ins_ready) begin
                is64  = (k != 2'b11);
                exp_d = is64 ? {slot_val(mpc + 32'd4), slot_val(mpc)}
                             : {32'h0, slot_val(mpc)};
                tag = (items == 0 && start[2]) ? "R10 upper first"
                    : (is64 ? "R4 wide issue" : "R3 standard issue");
                check(ins_data == exp_d && ins_pc == mpc && ins_is64 == is64, tag,
                      ins_data ^ 64'(ins_pc), exp_d ^ 64'(mpc));
                if (mpc[31:3] != lw) begin
                    wcnt++;
                    lw = mpc[31:3];
                end
                mpc = mpc + (is64 ? 32'd8 : 32'd4);
                items++;
                if (items == nitems) begin
                    if (chk_req)
                        check(req_cnt == wcnt, "R5 request count", 64'(req_cnt), 64'(wcnt));
                    done = 1;
                end
            end
            if (!done) tick(1'b0, '0);
        end
        if (!done) check(1'b0, "R3 stream stalled", 64'(items), 64'(nitems));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) kind_tab[i] = 2'b11;
        // sweep: lower-slot code x upper-slot code x start offset
        for (int c = 0; c < 32; c++) begin
            logic [31:0] base;
            base = 32'h1000 + 32'(c) * 32'd64;
            kind_tab[0] = 2'(c % 4);
            kind_tab[1] = 2'((c / 4) % 4);
            for (int i = 2; i < 16; i++) kind_tab[i] = 2'((i * 3 + c) % 4);
            pat = c;
            lat = (c % 3) + 1;
            do_reset();
            tick(1'b1, base + ((c / 16) != 0 ? 32'd4 : 32'd0));
            req_cnt = 0;
            run(base + ((c / 16) != 0 ? 32'd4 : 32'd0), 6, 1'b1);
        end
        // R9: redirect while a response is in flight, target with low bits set
        for (int i = 0; i < 16; i++) kind_tab[i] = 2'b11;
        pat = 5;
        lat = 3;
        do_reset();
        tick(1'b1, 32'h2000);
        req_cnt = 0;
        for (int g = 0; g < 20 && req_cnt == 0; g++) tick(1'b0, '0);
        tick(1'b1, 32'h3006);
        req_cnt = 0;
        run(32'h3006, 4, 1'b0);
        check(1'b1, "R9 flushed stream", 64'h0, 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL R1 watchdog expired actual=%0d expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule